// File: doc/BRIEF.md
# Vertical-Blanking Data Extractor

This block sits on the ground side of a video downlink. Data bits are carried on a set of lines inside the vertical blanking interval of the received picture, and this block takes them out again. It takes separated vertical and horizontal sync pulses and a one-bit sliced data level. It counts lines from the vertical sync to find the ten data lines of each field. On each of those lines it samples a fixed run of bits at the middle of each bit period and packs them into bytes. The bytes are handed on through a small FIFO to a serial transmitter.

Each data line starts with a header byte. The payload of a line is kept only when its header matches. A line whose header is wrong is dropped whole, and an error count goes up. On every data line, good or bad, the block raises a blanking output from the start of the data to the end of the active line. The analog path uses it to force those lines back to black, so the embedded bits never show on the monitor. Bit timing comes from counting system clocks, with a parameter that divides the clock down to the bit rate.

Top module: `vbi_extractor`

## Requirements
- R1: After reset `out_valid_o`, `blank_o`, `ovf_o` are 0 and `err_cnt_o` is 0.
- R2: All three inputs pass through a two-flop synchroniser. A rising edge of vertical sync sets the line number to 0, and each rising edge of horizontal sync adds one. Only lines FIRST_LINE to FIRST_LINE+NUM_SLOTS-1 carry data. Any other line yields no bytes, no blanking and no error count, whatever its data input.
- R3: The in-line clock count is 0 three clock edges after horizontal sync is first driven high, counts up once per clock and stops at LINE_END. On data lines `blank_o` is high exactly while that count lies in [SLOT_DELAY, LINE_END). It does this whether or not the header matches.
- R4: Bit k of a line occupies counts SLOT_DELAY+k*BIT_DIV to SLOT_DELAY+(k+1)*BIT_DIV-1, and is sampled BIT_DIV/2 counts into that period. Bits are packed into bytes most significant bit first, and 8*(1+PAYLOAD_BYTES) bits are taken per line.
- R5: The first byte of a line is the header. If it equals START_PAT (default 8'hA5), the PAYLOAD_BYTES bytes that follow are queued in order.
- R6: If the header differs from START_PAT, no byte of that line is queued, and `err_cnt_o` increases by one, saturating at its maximum. The count never decreases except by reset.
- R7: `out_valid_o` is high while the FIFO holds a byte. `out_data_o` is the oldest byte and stays stable until `out_ready_i` is high at a clock edge, which removes it.
- R8: A byte that arrives while the FIFO holds FIFO_DEPTH bytes is dropped and `ovf_o` goes high. It then stays high until reset, and bytes already queued are still delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (bit timing is divided from it) |
| rst_i | input | 1 | Synchronous reset, active high |
| vsync_i | input | 1 | Separated vertical sync, active high, asynchronous |
| hsync_i | input | 1 | Separated horizontal sync, active high, asynchronous |
| data_i | input | 1 | Sliced data level from the analog path, asynchronous |
| blank_o | output | 1 | High while the current data line must be forced to black |
| out_valid_o | output | 1 | A recovered byte is available |
| out_ready_i | input | 1 | Consumer takes the byte at this clock edge |
| out_data_o | output | 8 | Oldest recovered byte |
| err_cnt_o | output | ERR_W | Count of data lines dropped for a bad header |
| ovf_o | output | 1 | Sticky flag: a byte was lost to a full FIFO |

## Verification
The bench sends fields whose data lines sit at both ends of the slot range. It also puts valid-looking data on the lines just outside that range. An off-by-one line counter would queue extra bytes or lose the first or last slot. It checks `blank_o` one count before and one count after each edge of its window. A design that measured from the wrong sync edge, or left blanking off on a bad line, would miss one of those samples. Some headers differ from the pattern in only a single bit, and each byte takes both all-zero and all-one values. A design that sampled off-centre, packed bits in the wrong order or kept part of a bad line would then queue wrong or extra bytes. A run with the consumer stalled overfills the FIFO. The bench then expects exactly the first FIFO_DEPTH bytes, and checks that the overflow flag stays set once the FIFO has drained.

// File: rtl/vbi_extractor.sv
module vbi_extractor #(
  parameter int         FIRST_LINE    = 10,
  parameter int         NUM_SLOTS     = 10,
  parameter int         SLOT_DELAY    = 180,
  parameter int         BIT_DIV       = 12,
  parameter int         PAYLOAD_BYTES = 10,
  parameter int         LINE_END      = 1260,
  parameter logic [7:0] START_PAT     = 8'hA5,
  parameter int         FIFO_DEPTH    = 8,
  parameter int         ERR_W         = 8,
  parameter int         LINE_W        = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             data_i,
  output logic             blank_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             ovf_o
);
  localparam int TOTAL_BITS = 8 * (PAYLOAD_BYTES + 1);
  localparam int PIX_W = $clog2(LINE_END + 1);
  localparam int PH_W  = $clog2(BIT_DIV);
  localparam int BI_W  = $clog2(TOTAL_BITS + 1);
  localparam int AW    = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  localparam logic [PIX_W-1:0]  SD_P    = PIX_W'(SLOT_DELAY);
  localparam logic [PIX_W-1:0]  LE_P    = PIX_W'(LINE_END);
  localparam logic [LINE_W-1:0] FL_P    = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LAST_P  = LINE_W'(FIRST_LINE + NUM_SLOTS);
  localparam logic [PH_W-1:0]   PH_LAST = PH_W'(BIT_DIV - 1);
  localparam logic [PH_W-1:0]   PH_MID  = PH_W'(BIT_DIV / 2);
  localparam logic [BI_W-1:0]   BI_LAST = BI_W'(TOTAL_BITS - 1);
  localparam logic [BI_W-1:0]   BI_HDR  = BI_W'(8);
  localparam logic [AW-1:0]     A_LAST  = AW'(FIFO_DEPTH - 1);
  localparam logic [CW-1:0]     C_FULL  = CW'(FIFO_DEPTH);

  logic [2:0] vs_p, hs_p;
  logic [1:0] d_p;
  logic [LINE_W-1:0] line_q;
  logic [PIX_W-1:0]  pix_q;
  logic              run_q, slot_ok_q;
  logic [PH_W-1:0]   ph_q;
  logic [BI_W-1:0]   bi_q;
  logic [6:0]        sr_q;
  logic [7:0]        mem [FIFO_DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;

  wire vs_rise   = vs_p[1] & ~vs_p[2];
  wire hs_rise   = hs_p[1] & ~hs_p[2];
  wire in_slot   = (line_q >= FL_P) && (line_q < LAST_P);
  wire sample    = run_q && (ph_q == PH_MID);
  wire byte_done = sample && (bi_q[2:0] == 3'd7);
  wire is_hdr    = bi_q < BI_HDR;
  wire [7:0] new_byte = {sr_q, d_p[1]};
  wire full      = (cnt_q == C_FULL);
  wire push_req  = byte_done && !is_hdr && slot_ok_q;
  wire push      = push_req && !full;
  wire pop       = out_valid_o && out_ready_i;

  assign blank_o     = in_slot && (pix_q >= SD_P) && (pix_q < LE_P);
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vs_p <= '0; hs_p <= '0; d_p <= '0;
    end else begin
      vs_p <= {vs_p[1:0], vsync_i};
      hs_p <= {hs_p[1:0], hsync_i};
      d_p  <= {d_p[0], data_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_q <= '0;
      pix_q  <= LE_P;
    end else begin
      if (vs_rise) line_q <= '0;
      else if (hs_rise && line_q != '1) line_q <= line_q + 1'b1;
      if (hs_rise) pix_q <= '0;
      else if (pix_q != LE_P) pix_q <= pix_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0; ph_q <= '0; bi_q <= '0;
    end else if (hs_rise) begin
      run_q <= 1'b0;
    end else if (!run_q && in_slot && pix_q == SD_P) begin
      run_q <= 1'b1; ph_q <= '0; bi_q <= '0;
    end else if (run_q) begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        bi_q <= bi_q + 1'b1;
        if (bi_q == BI_LAST) run_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sr_q <= '0; slot_ok_q <= 1'b0; err_cnt_o <= '0;
    end else begin
      if (sample) sr_q <= new_byte[6:0];
      if (byte_done && is_hdr) begin
        slot_ok_q <= (new_byte == START_PAT);
        if (new_byte != START_PAT && err_cnt_o != '1) err_cnt_o <= err_cnt_o + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wp_q] <= new_byte;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovf_o <= 1'b0;
    end else begin
      if (push) wp_q <= (wp_q == A_LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == A_LAST) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_req && full) ovf_o <= 1'b1;
    end
  end
endmodule

module vbi_extractor_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             blank_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic [ERR_W-1:0] err_cnt_o,
  input logic             ovf_o
);
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |=> ovf_o);
  assert_hold_data_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  assert_err_monotonic_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (err_cnt_o >= $past(err_cnt_o)));
  assert_err_on_slot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_cnt_o != $past(err_cnt_o)) |-> $past(blank_o));
  assert_byte_on_slot_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(out_valid_o) |-> $past(blank_o));
endmodule

bind vbi_extractor vbi_extractor_chk #(.ERR_W(ERR_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .blank_o(blank_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o), .err_cnt_o(err_cnt_o),
  .ovf_o(ovf_o)
);

// File: tb/vbi_extractor_tb.sv
`timescale 1ns/1ps
module vbi_extractor_tb_top;
  localparam int FL = 3, NS = 10, SD = 6, BD = 4, PB = 2, LE = 106, FD = 4;
  localparam int NBITS = 8 * (PB + 1);
  localparam int LINE_LEN = LE + 10, HS_W = 4;

  logic clk = 0, rst = 1, vs = 0, hs = 0, din = 0, ready = 0;
  logic blank, valid, ovf;
  logic [7:0] dout;
  logic [7:0] err;

  int checks = 0, failures = 0, line_no = 0, exp_err = 0, exp_fill = 0, cyc = 0;
  bit hold = 0;
  logic [7:0] q[$];

  vbi_extractor #(.FIRST_LINE(FL), .NUM_SLOTS(NS), .SLOT_DELAY(SD), .BIT_DIV(BD),
    .PAYLOAD_BYTES(PB), .LINE_END(LE), .FIFO_DEPTH(FD)) dut_i (
    .clk_i(clk), .rst_i(rst), .vsync_i(vs), .hsync_i(hs), .data_i(din),
    .blank_o(blank), .out_valid_o(valid), .out_ready_i(ready), .out_data_o(dout),
    .err_cnt_o(err), .ovf_o(ovf));

  initial forever #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic do_vsync();
    @(negedge clk); vs = 1;
    repeat (4) @(negedge clk);
    vs = 0;
    repeat (4) @(negedge clk);
    line_no = 0;
  endtask

  task automatic send_line(input logic [7:0] h, input logic [7:0] b0, input logic [7:0] b1);
    logic [NBITS-1:0] bits;
    bit slot;
    bits = {h, b0, b1};
    line_no++;
    slot = (line_no >= FL) && (line_no < FL + NS);
    if (slot && h == 8'hA5) begin
      if (!hold) begin
        q.push_back(b0); q.push_back(b1);
      end else begin
        if (exp_fill < FD) begin q.push_back(b0); exp_fill++; end
        if (exp_fill < FD) begin q.push_back(b1); exp_fill++; end
      end
    end
    for (int n = 0; n < LINE_LEN; n++) begin
      @(negedge clk);
      hs = (n < HS_W);
      if (n >= SD + 3 && n < SD + 3 + NBITS * BD) din = bits[NBITS - 1 - (n - SD - 3) / BD];
      else din = 0;
      if (n == SD + 2) check(blank === 1'b0, "R3 blank before window", int'(blank), 0);
      if (n == SD + 3) check(blank === slot, "R3/R2 blank at window start", int'(blank), int'(slot));
      if (n == LE + 2) check(blank === slot, "R3 blank at window end", int'(blank), int'(slot));
      if (n == LE + 3) check(blank === 1'b0, "R3 blank after window", int'(blank), 0);
    end
    if (slot && h != 8'hA5) exp_err++;
    check(int'(err) == exp_err, "R6 error count", int'(err), exp_err);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 600 && (q.size() != 0 || valid); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, {tag, " all expected bytes delivered"}, q.size(), 0);
    check(valid === 1'b0, {tag, " FIFO empty after drain"}, int'(valid), 0);
  endtask

  function automatic logic [7:0] pay(input int ln, input int k);
    logic [7:0] v;
    v = 8'(ln * 37 + 11);
    if (ln == 4) v = 8'h00;
    if (ln == 12) v = 8'hFF;
    return (k == 0) ? v : ~v;
  endfunction

  // monitor: scoreboard pop and compare (R7, R4, R5)
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ready = hold ? 1'b0 : ((cyc % 3) != 2);
      if (!rst && valid && ready) begin
        if (q.size() == 0) check(1'b0, "R2/R5 unexpected byte", int'(dout), 0);
        else begin
          logic [7:0] e;
          e = q.pop_front();
          check(dout === e, "R7/R4 byte value", int'(dout), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(valid === 1'b0, "R1 valid at reset", int'(valid), 0);
    check(blank === 1'b0, "R1 blank at reset", int'(blank), 0);
    rst = 0;
    @(negedge clk);
    check(err === 8'd0, "R1 error count at reset", int'(err), 0);
    check(ovf === 1'b0, "R1 overflow at reset", int'(ovf), 0);

    // field 1: every line carries data; line 5 has a bad header
    do_vsync();
    for (int ln = 1; ln <= 14; ln++)
      send_line((ln == 5) ? 8'h5A : 8'hA5, pay(ln, 0), pay(ln, 1));
    drain("R5");
    check(int'(err) == 1, "R6 one bad line in field", int'(err), 1);

    // field 2: single-bit header error, then resync mid-field
    do_vsync();
    for (int ln = 1; ln <= 6; ln++)
      send_line((ln == 4) ? 8'hA4 : 8'hA5, pay(ln + 20, 0), pay(ln + 20, 1));
    do_vsync();
    for (int ln = 1; ln <= 4; ln++) send_line(8'hA5, pay(ln + 40, 0), pay(ln + 40, 1));
    drain("R2");
    check(ovf === 1'b0, "R8 no overflow yet", int'(ovf), 0);

    // overflow: consumer stalled, 6 bytes into depth 4
    hold = 1; exp_fill = 0;
    do_vsync();
    for (int ln = 1; ln <= 5; ln++) send_line(8'hA5, pay(ln + 60, 0), pay(ln + 60, 1));
    check(ovf === 1'b1, "R8 overflow flag set", int'(ovf), 1);
    check(valid === 1'b1, "R8 queued bytes kept", int'(valid), 1);
    hold = 0;
    drain("R8");
    check(ovf === 1'b1, "R8 overflow flag sticky", int'(ovf), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule